// File: doc/BRIEF.md
# Multi-mode host bus front end

This block sits between a processor and the core of a display controller. It accepts host accesses over one of three styles, chosen by two strap pins: a parallel bus with an enable strobe and a read/write level, a parallel bus with separate active-low read and write strobes, or a one-bit serial link clocked by the host. Whatever the style, each access becomes one request to the core: an instruction write, a status read, a display data write or a display data read.

All host pins are brought into the core clock domain through a synchronizer chain. The core sees a single-cycle request pulse carrying a two-bit transfer kind and a data byte. During a parallel read the block drives the 8-bit data bus straight from the pins. The byte comes from the core's display read port or from its status port, as the register-select line chooses.

The chip is selected only while one active-low select and one active-high select are both asserted. Dropping the selection shuts the data bus drivers off and throws away any serial byte that is only partly shifted in.

Top module: `host_bus_front`

## Requirements
- R1: The block is selected only when `cs_lo_n` is 0 and `cs_hi` is 1. With any other combination, activity on `rs`, `rd_e` and `wr_rw` produces no request and `db_oe` stays 0.
- R2: `db_oe` is 1 only while the block is selected, `par_sel` is 1 and a read strobe is asserted. In that state `db_out` equals `core_rdata` when `rs` is 1 and `core_status` when `rs` is 0.
- R3: `par_sel` = 1 selects a parallel style and `par_sel` = 0 selects serial. In serial mode, `style68` and the parallel strobes have no effect on requests or on `db_oe`.
- R4: With `style68` = 1, `wr_rw` = 1 with `rd_e` = 1 is a read and `wr_rw` = 0 with `rd_e` = 1 is a write. A write is issued when `rd_e` falls, and a read when `rd_e` falls at the end of the read.
- R5: With `style68` = 0, `rd_e` = 0 with `wr_rw` = 1 is a read and `wr_rw` = 0 with `rd_e` = 1 is a write. A write is issued when `wr_rw` rises, and a read when `rd_e` rises.
- R6: `req_kind` bit 1 is the access's `rs` and bit 0 is 1 for a read. The codes are 00 instruction write, 01 status read, 10 display data write and 11 display data read. `req_data` is the bus byte for a parallel write, the shifted byte for a serial write, and 0 for a read.
- R7: Each completed access gives exactly one `req_valid` pulse, one clock wide.
- R8: In serial mode, bits enter MSB first on rising edges of `sclk`. On the eighth bit a write is issued, with its kind chosen by `rs` at that time. Serial mode has no reads.
- R9: Deselecting the block in serial mode clears the shift register and the bit count, so a partial byte is discarded and the next byte starts from its first bit.
- R10: While `rst_n` is 0 and after its release, `req_valid` is 0 until an access completes.
- R11: A parallel access whose strobe is cut short by deselection issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_lo_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| par_sel | input | 1 | Strap: 1 parallel, 0 serial |
| style68 | input | 1 | Strap: 1 enable/level style, 0 separate strobes |
| rs | input | 1 | Register select: 1 display data, 0 instruction/status |
| rd_e | input | 1 | Enable strobe (style68=1) or active-low read (style68=0) |
| wr_rw | input | 1 | Read/write level (style68=1) or active-low write (style68=0) |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data |
| db_in | input | 8 | Data bus input from the pads |
| db_out | output | 8 | Data bus value to drive |
| db_oe | output | 1 | Data bus output enable |
| core_rdata | input | 8 | Display read data from the core |
| core_status | input | 8 | Status byte from the core |
| req_valid | output | 1 | Single-cycle request pulse |
| req_kind | output | 2 | Transfer kind {rs, read} |
| req_data | output | 8 | Request data byte |

## Verification
The bench runs reads and writes of both register-select values in both parallel styles and a serial byte of each kind. Requests are matched against an expected queue, so a design that issued a strobe twice, or that confused the edge carrying a write, would give extra or mismatched requests. The bench deselects after three serial bits. A design that kept its partial state would then misalign the next byte. Strobes are toggled while the block is deselected or in serial mode, and a write strobe is cut short by deselection; a design that gated badly would issue requests or drive the bus there. The enable and bus value are compared on every clock, so a bus that turned on in the wrong mode would be caught at once.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
   typedef enum logic [1:0] {
      KIND_INSTR_WR  = 2'b00,
      KIND_STATUS_RD = 2'b01,
      KIND_DATA_WR   = 2'b10,
      KIND_DATA_RD   = 2'b11
   } xfer_kind_t;
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbf_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("hbf_sync width must be positive");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hbf_par.sv
module hbf_par #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          m68,
   input  logic          rs,
   input  logic          strb_a,
   input  logic          strb_b,
   input  logic [DW-1:0] din,
   output logic          pulse,
   output logic [1:0]    kind,
   output logic [DW-1:0] data
);
   logic rd_now, wr_now, rd_q, wr_q, rs_q;
   logic [DW-1:0] d_q;
   logic rd_done, wr_done;

   always_comb begin
      if (m68) begin
         rd_now = sel & strb_a & strb_b;
         wr_now = sel & strb_a & ~strb_b;
      end else begin
         rd_now = sel & ~strb_a & strb_b;
         wr_now = sel & strb_a & ~strb_b;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
         rs_q <= 1'b0;
         d_q  <= '0;
      end else begin
         rd_q <= rd_now;
         wr_q <= wr_now;
         if (rd_now || wr_now) begin
            rs_q <= rs;
            d_q  <= din;
         end
      end
   end

   assign rd_done = rd_q & ~rd_now & sel;
   assign wr_done = wr_q & ~wr_now & sel;
   assign pulse   = rd_done | wr_done;
   assign kind    = {rs_q, rd_done};
   assign data    = wr_done ? d_q : '0;

   // R7
   par_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
   // R4
   par_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_done && wr_done));
endmodule

// File: rtl/hbf_ser.sv
module hbf_ser #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          sclk,
   input  logic          sdin,
   input  logic          rs,
   output logic          pulse,
   output logic [1:0]    kind,
   output logic [DW-1:0] data
);
   localparam int CW = (DW > 2) ? $clog2(DW) : 1;
   localparam logic [CW-1:0] LAST = CW'(DW - 1);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("hbf_ser needs at least two bits per byte");
      end
   endgenerate

   logic          sclk_q, rise;
   logic [CW-1:0] cnt;
   logic [DW-1:0] sh;

   assign rise  = sclk & ~sclk_q;
   assign pulse = sel & rise & (cnt == LAST);
   assign kind  = {rs, 1'b0};
   assign data  = {sh[DW-2:0], sdin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cnt    <= '0;
         sh     <= '0;
      end else begin
         sclk_q <= sclk;
         if (!sel) begin
            cnt <= '0;
            sh  <= '0;
         end else if (rise) begin
            sh  <= {sh[DW-2:0], sdin};
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
   end

   // R9
   ser_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (cnt == '0 && sh == '0));
endmodule

// File: rtl/host_bus_front.sv
module host_bus_front #(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_lo_n,
   input  logic          cs_hi,
   input  logic          par_sel,
   input  logic          style68,
   input  logic          rs,
   input  logic          rd_e,
   input  logic          wr_rw,
   input  logic          sclk,
   input  logic          sdin,
   input  logic [DW-1:0] db_in,
   output logic [DW-1:0] db_out,
   output logic          db_oe,
   input  logic [DW-1:0] core_rdata,
   input  logic [DW-1:0] core_status,
   output logic          req_valid,
   output logic [1:0]    req_kind,
   output logic [DW-1:0] req_data
);
   import hbf_pkg::*;

   localparam int NCTL = 9;
   localparam int SW   = NCTL + DW;

   logic [SW-1:0] raw, syn;
   logic s_cs_lo_n, s_cs_hi, s_par, s_m68, s_rs, s_a, s_b, s_sclk, s_sdin;
   logic [DW-1:0] s_db;
   logic sel_s;
   logic par_p, ser_p;
   logic [1:0] par_k, ser_k;
   logic [DW-1:0] par_d, ser_d;
   logic pin_sel, pin_rd;

   assign raw = {cs_lo_n, cs_hi, par_sel, style68, rs, rd_e, wr_rw, sclk, sdin, db_in};

   hbf_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

   assign {s_cs_lo_n, s_cs_hi, s_par, s_m68, s_rs, s_a, s_b, s_sclk, s_sdin, s_db} = syn;
   assign sel_s = ~s_cs_lo_n & s_cs_hi;

   hbf_par #(.DW(DW)) u_par (
      .clk(clk), .rst_n(rst_n), .sel(sel_s & s_par), .m68(s_m68), .rs(s_rs),
      .strb_a(s_a), .strb_b(s_b), .din(s_db),
      .pulse(par_p), .kind(par_k), .data(par_d));

   hbf_ser #(.DW(DW)) u_ser (
      .clk(clk), .rst_n(rst_n), .sel(sel_s & ~s_par), .sclk(s_sclk),
      .sdin(s_sdin), .rs(s_rs),
      .pulse(ser_p), .kind(ser_k), .data(ser_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_kind  <= KIND_INSTR_WR;
         req_data  <= '0;
      end else begin
         req_valid <= par_p | ser_p;
         if (par_p) begin
            req_kind <= par_k;
            req_data <= par_d;
         end else if (ser_p) begin
            req_kind <= ser_k;
            req_data <= ser_d;
         end
      end
   end

   assign pin_sel = ~cs_lo_n & cs_hi & par_sel;
   assign pin_rd  = style68 ? (rd_e & wr_rw) : (~rd_e & wr_rw);
   assign db_oe   = pin_sel & pin_rd;
   assign db_out  = rs ? core_rdata : core_status;

   // R3
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(par_p && ser_p));
   // R7
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);
   // R2
   oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_oe |-> (par_sel && cs_hi && !cs_lo_n));
   // R8
   ser_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_p |-> !ser_k[0]);
endmodule

// File: tb/host_bus_front_test.sv
module host_bus_front_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_lo_n = 1'b1, cs_hi = 1'b0, par_sel = 1'b1, style68 = 1'b1;
   logic rs = 1'b0, rd_e = 1'b0, wr_rw = 1'b1, sclk = 1'b0, sdin = 1'b0;
   logic [7:0] db_in = 8'h00, core_rdata = 8'hA5, core_status = 8'h3C;
   logic [7:0] db_out, req_data;
   logic db_oe, req_valid;
   logic [1:0] req_kind;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [9:0] expq [$];

   always #2.5 clk = ~clk;

   host_bus_front uut (
      .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
      .par_sel(par_sel), .style68(style68), .rs(rs), .rd_e(rd_e),
      .wr_rw(wr_rw), .sclk(sclk), .sdin(sdin), .db_in(db_in),
      .db_out(db_out), .db_oe(db_oe), .core_rdata(core_rdata),
      .core_status(core_status), .req_valid(req_valid),
      .req_kind(req_kind), .req_data(req_data));

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // per-clock reference comparison of the bus enable and value, and of requests
   always @(negedge clk) begin
      logic exp_oe;
      logic [9:0] e;
      cycles++;
      if (cycles > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         summary();
      end
      if (rst_n) begin
         exp_oe = !cs_lo_n && cs_hi && par_sel &&
                  (style68 ? (rd_e && wr_rw) : (!rd_e && wr_rw));
         checks++;
         if (db_oe !== exp_oe) begin
            errors++;
            $display("FAIL R1/R2/R3 db_oe actual %0b expected %0b", db_oe, exp_oe);
         end
         if (exp_oe) begin
            checks++;
            if (db_out !== (rs ? core_rdata : core_status)) begin
               errors++;
               $display("FAIL R2 db_out actual %h expected %h", db_out,
                        rs ? core_rdata : core_status);
            end
         end
         if (req_valid) begin
            checks++;
            if (expq.size() == 0) begin
               errors++;
               $display("FAIL R7/R1 unexpected request actual %b/%h expected none",
                        req_kind, req_data);
            end else begin
               e = expq.pop_front();
               if ({req_kind, req_data} !== e) begin
                  errors++;
                  $display("FAIL R6 request actual %b/%h expected %b/%h",
                           req_kind, req_data, e[9:8], e[7:0]);
               end
            end
         end
      end
   end

   task automatic wait_clk(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drained(string tag);
      wait_clk(10);
      checks++;
      if (expq.size() != 0) begin
         errors++;
         $display("FAIL %s missing requests actual %0d pending expected 0", tag, expq.size());
         expq.delete();
      end
   endtask

   // change straps while deselected, with idle strobe levels
   task automatic set_mode(logic p, logic m);
      cs_lo_n = 1'b1; cs_hi = 1'b0;
      wait_clk(6);
      par_sel = p; style68 = m;
      rd_e = m ? 1'b0 : 1'b1; wr_rw = 1'b1; sclk = 1'b0;
      wait_clk(6);
      cs_lo_n = 1'b0; cs_hi = 1'b1;
      wait_clk(6);
   endtask

   task automatic pwrite(logic r, logic [7:0] d);
      rs = r; db_in = d;
      expq.push_back({r, 1'b0, d});
      if (style68) begin
         wr_rw = 1'b0; wait_clk(6);
         rd_e = 1'b1; wait_clk(8);
         rd_e = 1'b0; wait_clk(8);
         wr_rw = 1'b1; wait_clk(4);
      end else begin
         wr_rw = 1'b0; wait_clk(8);
         wr_rw = 1'b1; wait_clk(8);
      end
   endtask

   task automatic pread(logic r);
      rs = r;
      expq.push_back({r, 1'b1, 8'h00});
      if (style68) begin
         wr_rw = 1'b1; wait_clk(4);
         rd_e = 1'b1; wait_clk(8);
         rd_e = 1'b0; wait_clk(8);
      end else begin
         rd_e = 1'b0; wait_clk(8);
         rd_e = 1'b1; wait_clk(8);
      end
   endtask

   task automatic sbits(logic [7:0] b, int n);
      for (int i = 7; i > 7 - n; i--) begin
         sdin = b[i]; wait_clk(4);
         sclk = 1'b1; wait_clk(4);
         sclk = 1'b0;
      end
      wait_clk(4);
   endtask

   initial begin
      wait_clk(3);
      checks++;
      if (req_valid !== 1'b0 || db_oe !== 1'b0) begin
         errors++;
         $display("FAIL R10 reset actual valid %b oe %b expected 0 0", req_valid, db_oe);
      end
      rst_n = 1'b1;
      wait_clk(4);

      // R4: enable/level style, all four kinds
      set_mode(1'b1, 1'b1);
      pwrite(1'b0, 8'h5A); pwrite(1'b1, 8'hC3);
      pread(1'b0); pread(1'b1);
      drained("R4");

      // R5: separate strobe style, all four kinds
      set_mode(1'b1, 1'b0);
      pwrite(1'b1, 8'h81); pwrite(1'b0, 8'h7E);
      core_rdata = 8'h19; core_status = 8'hE2;
      pread(1'b1); pread(1'b0);
      drained("R5");

      // R1: strobes while deselected, two bad select combinations
      cs_lo_n = 1'b1; cs_hi = 1'b1; wait_clk(4);
      rd_e = 1'b0; wait_clk(8); rd_e = 1'b1; wait_clk(4);
      wr_rw = 1'b0; wait_clk(8); wr_rw = 1'b1; wait_clk(4);
      cs_lo_n = 1'b0; cs_hi = 1'b0; wait_clk(4);
      rd_e = 1'b0; wait_clk(8); rd_e = 1'b1; wait_clk(4);
      wr_rw = 1'b0; wait_clk(8); wr_rw = 1'b1; wait_clk(4);
      cs_hi = 1'b1; wait_clk(6);
      drained("R1");

      // R11: write strobe cut short by deselection
      db_in = 8'hEE; rs = 1'b1;
      wr_rw = 1'b0; wait_clk(8);
      cs_lo_n = 1'b1; wait_clk(8);
      wr_rw = 1'b1; wait_clk(8);
      cs_lo_n = 1'b0; wait_clk(8);
      drained("R11");

      // R8: serial bytes of both kinds, style strap both values (R3)
      set_mode(1'b0, 1'b0);
      rs = 1'b1; expq.push_back({2'b10, 8'hB4}); sbits(8'hB4, 8);
      style68 = 1'b1; wait_clk(4);
      rs = 1'b0; expq.push_back({2'b00, 8'h6D}); sbits(8'h6D, 8);
      drained("R8");

      // R3: parallel strobes in serial mode are ignored
      rd_e = 1'b1; wr_rw = 1'b1; wait_clk(8);
      rd_e = 1'b0; wait_clk(8); rd_e = 1'b1; wait_clk(8);
      wr_rw = 1'b0; wait_clk(8); wr_rw = 1'b1; wait_clk(8);
      drained("R3");

      // R9: partial byte then deselect, next byte aligned
      rs = 1'b1;
      sbits(8'hFF, 3);
      cs_lo_n = 1'b1; wait_clk(6);
      cs_lo_n = 1'b0; wait_clk(6);
      expq.push_back({2'b10, 8'h29}); sbits(8'h29, 8);
      drained("R9");

      summary();
   end
endmodule